// File: doc/BRIEF.md
# Saturating Event Counter Bank with Interrupt Status

This block keeps a bank of saturating event counters for a packet datapath: received frames, bytes, dropped frames, dropped bytes, checksum failures, flow-control frames, broadcast and multicast frames. Each counter takes a valid pulse and an increment amount per cycle. Each counter owns a sticky overflow flag. One more flag records a completed frame. Together these flags form a status word. A mask word selects which flags drive the single interrupt line.

Software reaches the block through a small word-addressed register port with a one-cycle read latency. It can read each counter, which also clears that counter's overflow flag. It can clear status flags by writing ones and can force flags through a second, write-one-to-set view of the same status word. It can also return the whole block to its power-on state with a self-clearing reset command. When the block enable is low, the counters freeze and no hardware event can raise a flag. Flags that are already set stay set.

Register map: 0 = reset command, 1 = status (read, write-one-to-clear), 2 = mask (read/write), 3 = force view (read returns status, write-one-to-set), 16+i = counter i.

Top module: `stat_block`

## Requirements
- R1: After rst_n is released, every counter, the status word and the mask all read 0, and irq is 0.
- R2: While blk_en is 1, a cycle with evt_valid[i] set adds evt_amt slice i (bits i*AMT_W upward) to counter i. A read of address 16+i presents that counter on reg_rdata in the cycle after reg_rd.
- R3: An increment that would exceed 2^CNT_W-1 leaves counter i at 2^CNT_W-1. At the same clock edge it sets status bit i+1. Further increments keep the counter at that maximum.
- R4: While blk_en is 0, the counters hold their value, no event, frame completion or overflow sets a status bit, and status bits that are already set keep their value.
- R5: A read of counter i clears status bit i+1 and leaves the counter value unchanged.
- R6: Writing address 1 clears every status bit whose write-data bit is 1. Bits written 0 keep their value. The clear shows in both the status view and the force view.
- R7: Writing address 3 sets every status bit whose write-data bit is 1. A read of address 3 returns the same value as a read of address 1.
- R8: If a status bit is set by hardware and cleared by software in the same cycle, it ends set.
- R9: irq equals the OR over all bits of status AND NOT mask, registered, so it follows a status or mask change by one clock.
- R10: A write to address 0 with bit 8 set clears all counters, the status word and the mask at that edge. A write to address 0 with bit 8 clear changes nothing.
- R11: A frame_done pulse while blk_en is 1 sets status bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| blk_en | input | 1 | Block enable; low freezes counters and blocks new flags |
| evt_valid | input | NUM_CNT | Per-counter increment strobe |
| evt_amt | input | NUM_CNT*AMT_W | Per-counter increment amounts, counter i at bits i*AMT_W |
| frame_done | input | 1 | Completed-frame pulse, sets status bit 0 |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Register word address |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Read data, valid the cycle after reg_rd |
| irq | output | 1 | Interrupt request |

## Verification
Counter values, status bits and the mask all change at the edge that samples the stimulus. A read issued in the following cycle therefore returns the new value one edge later. irq lags status and mask by one extra edge. The bench drives every input on the falling edge and samples reg_rdata on the falling edge right after the read edge. Before every irq check it lets one idle cycle pass after the last status or mask change, so each result is observed in the cycle it is due.

// File: rtl/stat_pkg.sv
package stat_pkg;
   // register word addresses
   localparam int ADR_SRST     = 0;
   localparam int ADR_STATUS   = 1;
   localparam int ADR_MASK     = 2;
   localparam int ADR_FORCE    = 3;
   localparam int ADR_CNT_BASE = 16;

   // status bit carrying the frame-completion flag
   localparam int STAT_FRAME_BIT = 0;

   // status bit that holds the overflow flag of counter idx
   function automatic int ovf_bit(input int idx);
      return idx + 1;
   endfunction
endpackage

// File: rtl/stat_counter.sv
module stat_counter #(
   parameter int CNT_W = 32,
   parameter int AMT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             en,
   input  logic             inc_vld,
   input  logic [AMT_W-1:0] inc_amt,
   output logic [CNT_W-1:0] cnt,
   output logic             ovf
);
   localparam int SUM_W = CNT_W + 1;
   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   logic [SUM_W-1:0] sum;
   logic             carry;
   logic             bump;

   assign sum   = {1'b0, cnt} + SUM_W'(inc_amt);
   assign carry = sum[CNT_W];
   assign bump  = en & inc_vld;
   assign ovf   = bump & carry;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (clr) begin
         cnt <= '0;
      end else if (bump) begin
         cnt <= carry ? CNT_MAX : sum[CNT_W-1:0];
      end
   end
endmodule

// File: rtl/stat_status.sv
module stat_status #(
   parameter int SW      = 9,
   parameter bit IRQ_REG = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic [SW-1:0] hw_set,
   input  logic [SW-1:0] sw_clr,
   input  logic [SW-1:0] sw_set,
   input  logic          mask_we,
   input  logic [SW-1:0] mask_wd,
   output logic [SW-1:0] status,
   output logic [SW-1:0] mask,
   output logic          irq
);
   logic [SW-1:0] status_d;
   logic          irq_d;

   // set sources win over a clear that lands in the same cycle
   assign status_d = (status & ~sw_clr) | hw_set | sw_set;
   assign irq_d    = |(status & ~mask);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         status <= '0;
         mask   <= '0;
      end else if (clr) begin
         status <= '0;
         mask   <= '0;
      end else begin
         status <= status_d;
         if (mask_we) mask <= mask_wd;
      end
   end

   generate
      if (IRQ_REG) begin : g_irq_reg
         logic irq_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) irq_q <= 1'b0;
            else        irq_q <= irq_d;
         end
         assign irq = irq_q;
      end else begin : g_irq_comb
         assign irq = irq_d;
      end
   endgenerate
endmodule

// File: rtl/stat_regs.sv
module stat_regs
   import stat_pkg::*;
#(
   parameter int NUM_CNT = 8,
   parameter int CNT_W   = 32,
   parameter int SW      = 9,
   parameter int ADDR_W  = 5,
   parameter int DATA_W  = 32,
   parameter int RST_BIT = 8
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     reg_wr,
   input  logic                     reg_rd,
   input  logic [ADDR_W-1:0]        reg_addr,
   input  logic [DATA_W-1:0]        reg_wdata,
   input  logic [SW-1:0]            status,
   input  logic [SW-1:0]            mask,
   input  logic [NUM_CNT*CNT_W-1:0] cnt_flat,
   output logic                     soft_clr,
   output logic [SW-1:0]            sw_clr,
   output logic [SW-1:0]            sw_set,
   output logic                     mask_we,
   output logic [SW-1:0]            mask_wd,
   output logic [NUM_CNT-1:0]       cnt_rd,
   output logic [DATA_W-1:0]        reg_rdata
);
   localparam logic [ADDR_W-1:0] A_SRST   = ADDR_W'(ADR_SRST);
   localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(ADR_STATUS);
   localparam logic [ADDR_W-1:0] A_MASK   = ADDR_W'(ADR_MASK);
   localparam logic [ADDR_W-1:0] A_FORCE  = ADDR_W'(ADR_FORCE);

   logic              unused_wdata;
   logic [DATA_W-1:0] cnt_rdata;
   logic [DATA_W-1:0] rdata_d;

   assign unused_wdata = ^reg_wdata;

   assign soft_clr = reg_wr && (reg_addr == A_SRST) && reg_wdata[RST_BIT];
   assign sw_clr   = (reg_wr && reg_addr == A_STATUS) ? reg_wdata[SW-1:0] : '0;
   assign sw_set   = (reg_wr && reg_addr == A_FORCE)  ? reg_wdata[SW-1:0] : '0;
   assign mask_we  = reg_wr && (reg_addr == A_MASK);
   assign mask_wd  = reg_wdata[SW-1:0];

   generate
      for (genvar gi = 0; gi < NUM_CNT; gi++) begin : g_hit
         assign cnt_rd[gi] = reg_rd && (reg_addr == ADDR_W'(ADR_CNT_BASE + gi));
      end
   endgenerate

   always_comb begin
      cnt_rdata = '0;
      for (int i = 0; i < NUM_CNT; i++) begin
         if (cnt_rd[i]) cnt_rdata = cnt_rdata | DATA_W'(cnt_flat[i*CNT_W +: CNT_W]);
      end
   end

   always_comb begin
      unique case (reg_addr)
         A_STATUS, A_FORCE: rdata_d = DATA_W'(status);
         A_MASK:            rdata_d = DATA_W'(mask);
         default:           rdata_d = cnt_rdata;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      reg_rdata <= '0;
      else if (reg_rd) reg_rdata <= rdata_d;
   end
endmodule

// File: rtl/stat_block.sv
module stat_block
   import stat_pkg::*;
#(
   parameter int NUM_CNT = 8,
   parameter int CNT_W   = 32,
   parameter int AMT_W   = 16,
   parameter int ADDR_W  = 5,
   parameter int DATA_W  = 32,
   parameter int RST_BIT = 8,
   parameter bit IRQ_REG = 1'b1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     blk_en,
   input  logic [NUM_CNT-1:0]       evt_valid,
   input  logic [NUM_CNT*AMT_W-1:0] evt_amt,
   input  logic                     frame_done,
   input  logic                     reg_wr,
   input  logic                     reg_rd,
   input  logic [ADDR_W-1:0]        reg_addr,
   input  logic [DATA_W-1:0]        reg_wdata,
   output logic [DATA_W-1:0]        reg_rdata,
   output logic                     irq
);
   localparam int SW = NUM_CNT + 1;

   generate
      if (AMT_W > CNT_W) begin : g_bad_amt
         $error("stat_block: AMT_W must not exceed CNT_W");
      end
      if (CNT_W > DATA_W) begin : g_bad_cnt
         $error("stat_block: CNT_W must fit in DATA_W");
      end
      if (SW > DATA_W) begin : g_bad_sw
         $error("stat_block: status word must fit in DATA_W");
      end
      if (RST_BIT >= DATA_W) begin : g_bad_rst
         $error("stat_block: RST_BIT outside data word");
      end
      if (ADR_CNT_BASE + NUM_CNT > (1 << ADDR_W)) begin : g_bad_addr
         $error("stat_block: counters do not fit the address space");
      end
   endgenerate

   logic [NUM_CNT*CNT_W-1:0] cnt_flat;
   logic [NUM_CNT-1:0]       cnt_ovf;
   logic [NUM_CNT-1:0]       cnt_rd;
   logic [SW-1:0]            status_q;
   logic [SW-1:0]            mask_q;
   logic [SW-1:0]            hw_set;
   logic [SW-1:0]            sw_clr_reg;
   logic [SW-1:0]            sw_clr;
   logic [SW-1:0]            sw_set;
   logic                     soft_clr;
   logic                     mask_we;
   logic [SW-1:0]            mask_wd;

   generate
      for (genvar gi = 0; gi < NUM_CNT; gi++) begin : g_cnt
         stat_counter #(
            .CNT_W (CNT_W),
            .AMT_W (AMT_W)
         ) u_cnt (
            .clk     (clk),
            .rst_n   (rst_n),
            .clr     (soft_clr),
            .en      (blk_en),
            .inc_vld (evt_valid[gi]),
            .inc_amt (evt_amt[gi*AMT_W +: AMT_W]),
            .cnt     (cnt_flat[gi*CNT_W +: CNT_W]),
            .ovf     (cnt_ovf[gi])
         );
      end
   endgenerate

   // counter overflow flags sit above the frame flag; reading a counter clears its flag
   assign hw_set = {cnt_ovf, frame_done & blk_en};
   assign sw_clr = sw_clr_reg | {cnt_rd, 1'b0};

   stat_status #(
      .SW      (SW),
      .IRQ_REG (IRQ_REG)
   ) u_status (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (soft_clr),
      .hw_set  (hw_set),
      .sw_clr  (sw_clr),
      .sw_set  (sw_set),
      .mask_we (mask_we),
      .mask_wd (mask_wd),
      .status  (status_q),
      .mask    (mask_q),
      .irq     (irq)
   );

   stat_regs #(
      .NUM_CNT (NUM_CNT),
      .CNT_W   (CNT_W),
      .SW      (SW),
      .ADDR_W  (ADDR_W),
      .DATA_W  (DATA_W),
      .RST_BIT (RST_BIT)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_wr    (reg_wr),
      .reg_rd    (reg_rd),
      .reg_addr  (reg_addr),
      .reg_wdata (reg_wdata),
      .status    (status_q),
      .mask      (mask_q),
      .cnt_flat  (cnt_flat),
      .soft_clr  (soft_clr),
      .sw_clr    (sw_clr_reg),
      .sw_set    (sw_set),
      .mask_we   (mask_we),
      .mask_wd   (mask_wd),
      .cnt_rd    (cnt_rd),
      .reg_rdata (reg_rdata)
   );
endmodule

// File: rtl/stat_block_chk.sv
module stat_block_chk
   import stat_pkg::*;
#(
   parameter int NUM_CNT = 8,
   parameter int CNT_W   = 32,
   parameter int ADDR_W  = 5,
   parameter int DATA_W  = 32,
   parameter int RST_BIT = 8,
   parameter bit IRQ_REG = 1'b1
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic                     blk_en,
   input logic                     frame_done,
   input logic                     reg_wr,
   input logic [ADDR_W-1:0]        reg_addr,
   input logic [DATA_W-1:0]        reg_wdata,
   input logic [NUM_CNT*CNT_W-1:0] cnt_flat,
   input logic [NUM_CNT:0]         status_q,
   input logic [NUM_CNT:0]         mask_q,
   input logic                     irq
);
   localparam logic [CNT_W-1:0] CMAX = '1;

   logic srst_hit;
   logic force_hit;
   assign srst_hit  = reg_wr && (reg_addr == ADDR_W'(ADR_SRST)) && reg_wdata[RST_BIT];
   assign force_hit = reg_wr && (reg_addr == ADDR_W'(ADR_FORCE));

   // R4: frozen counters while disabled
   a_r4_cnt_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!blk_en && !srst_hit) |=> $stable(cnt_flat));

   // R4: no flag rises from hardware while disabled
   a_r4_no_new_flag: assert property (@(posedge clk) disable iff (!rst_n)
      (!blk_en && !srst_hit && !force_hit) |=> ((status_q & ~$past(status_q)) == '0));

   // R11: completed frame raises the frame flag
   a_r11_frame_flag: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_done && blk_en && !srst_hit) |=> status_q[STAT_FRAME_BIT]);

   generate
      for (genvar gi = 0; gi < NUM_CNT; gi++) begin : g_cnt_chk
         // R3: a saturated counter stays at its maximum
         a_r3_sat_stays: assert property (@(posedge clk) disable iff (!rst_n)
            (cnt_flat[gi*CNT_W +: CNT_W] == CMAX && !srst_hit)
            |=> (cnt_flat[gi*CNT_W +: CNT_W] == CMAX));
         // R2: counters never wrap downward
         a_r2_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
            !srst_hit |=> (cnt_flat[gi*CNT_W +: CNT_W] >= $past(cnt_flat[gi*CNT_W +: CNT_W])));
      end
      if (IRQ_REG) begin : g_irq_chk
         // R9: interrupt follows unmasked status one clock later
         a_r9_irq_follows: assert property (@(posedge clk) disable iff (!rst_n)
            1'b1 |=> (irq == $past(|(status_q & ~mask_q))));
      end
   endgenerate
endmodule

bind stat_block stat_block_chk #(
   .NUM_CNT (NUM_CNT),
   .CNT_W   (CNT_W),
   .ADDR_W  (ADDR_W),
   .DATA_W  (DATA_W),
   .RST_BIT (RST_BIT),
   .IRQ_REG (IRQ_REG)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .blk_en     (blk_en),
   .frame_done (frame_done),
   .reg_wr     (reg_wr),
   .reg_addr   (reg_addr),
   .reg_wdata  (reg_wdata),
   .cnt_flat   (cnt_flat),
   .status_q   (status_q),
   .mask_q     (mask_q),
   .irq        (irq)
);

// File: tb/stat_block_test.sv
`timescale 1ns/1ps
module stat_block_test;
   localparam int NC = 8;
   localparam int CW = 20;
   localparam int AW = 16;
   localparam int ADW = 5;
   localparam int DW = 32;
   localparam logic [31:0] CMAX = 32'h000F_FFFF;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            blk_en = 1'b0;
   logic [NC-1:0]   evt_valid = '0;
   logic [NC*AW-1:0] evt_amt = '0;
   logic            frame_done = 1'b0;
   logic            reg_wr = 1'b0;
   logic            reg_rd = 1'b0;
   logic [ADW-1:0]  reg_addr = '0;
   logic [DW-1:0]   reg_wdata = '0;
   logic [DW-1:0]   reg_rdata;
   logic            irq;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   stat_block #(.NUM_CNT(NC), .CNT_W(CW), .AMT_W(AW), .ADDR_W(ADW), .DATA_W(DW)) uut (
      .clk(clk), .rst_n(rst_n), .blk_en(blk_en), .evt_valid(evt_valid), .evt_amt(evt_amt),
      .frame_done(frame_done), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
   );

   typedef struct packed {
      logic [2:0]  idx;
      logic [15:0] amt;
      logic [31:0] exp;
   } vec_t;

   localparam vec_t VECS [9] = '{
      '{3'd0, 16'd5,     32'd5},
      '{3'd0, 16'd10,    32'd15},
      '{3'd1, 16'd1500,  32'd1500},
      '{3'd2, 16'd0,     32'd0},
      '{3'd3, 16'hFFFF,  32'd65535},
      '{3'd3, 16'd1,     32'd65536},
      '{3'd7, 16'd64,    32'd64},
      '{3'd5, 16'd7,     32'd7},
      '{3'd1, 16'd100,   32'd1600}
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic rd(input int addr, output logic [31:0] val);
      reg_rd = 1'b1; reg_addr = ADW'(addr);
      step();
      reg_rd = 1'b0;
      val = reg_rdata;
   endtask

   task automatic wr(input int addr, input logic [31:0] data);
      reg_wr = 1'b1; reg_addr = ADW'(addr); reg_wdata = data;
      step();
      reg_wr = 1'b0; reg_wdata = '0;
   endtask

   task automatic evt(input int idx, input logic [15:0] amt);
      evt_valid[idx] = 1'b1; evt_amt[idx*AW +: AW] = amt;
      step();
      evt_valid = '0; evt_amt = '0;
   endtask

   task automatic pulse_frame();
      frame_done = 1'b1;
      step();
      frame_done = 1'b0;
   endtask

   task automatic summary();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
   endtask

   initial begin
      #(5.0 * 150000);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         summary();
         $finish;
      end
   end

   initial begin
      logic [31:0] v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      step();

      // R1: reset state
      chk("R1 irq", {31'd0, irq}, 32'd0);
      rd(1, v); chk("R1 status", v, 32'd0);
      rd(2, v); chk("R1 mask", v, 32'd0);
      rd(16, v); chk("R1 counter0", v, 32'd0);

      // R2: vector table of increments
      blk_en = 1'b1;
      for (int k = 0; k < 9; k++) begin
         evt(int'(VECS[k].idx), VECS[k].amt);
         rd(16 + int'(VECS[k].idx), v);
         chk("R2 counter", v, VECS[k].exp);
      end
      rd(1, v); chk("R2 no flags", v, 32'd0);

      // R11, R9: frame flag and interrupt
      pulse_frame();
      rd(1, v); chk("R11 frame flag", v, 32'd1);
      chk("R9 irq unmasked", {31'd0, irq}, 32'd1);
      wr(2, 32'd1);
      step();
      chk("R9 irq masked", {31'd0, irq}, 32'd0);
      rd(2, v); chk("R9 mask readback", v, 32'd1);
      wr(1, 32'd1);
      rd(1, v); chk("R6 clear frame flag", v, 32'd0);

      // R3: saturation of counter 4
      for (int k = 0; k < 17; k++) evt(4, 16'hFFFF);
      rd(1, v); chk("R3 overflow flag", v, 32'h20);
      chk("R9 irq on overflow", {31'd0, irq}, 32'd1);
      evt(4, 16'd3);
      rd(20, v); chk("R3 saturated value", v, CMAX);
      rd(1, v); chk("R5 read clears flag", v, 32'd0);
      rd(20, v); chk("R5 value kept", v, CMAX);

      // R7: force view
      wr(3, 32'h4);
      rd(3, v); chk("R7 force view", v, 32'h4);
      rd(1, v); chk("R7 status view", v, 32'h4);

      // R4: disabled block
      blk_en = 1'b0;
      pulse_frame();
      evt(0, 16'd9);
      evt(4, 16'd5);
      rd(1, v); chk("R4 flags unchanged", v, 32'h4);
      rd(16, v); chk("R4 counter held", v, 32'd15);
      wr(1, 32'h4);
      rd(3, v); chk("R6 clear in force view", v, 32'd0);

      // R8: set beats clear
      blk_en = 1'b1;
      frame_done = 1'b1; reg_wr = 1'b1; reg_addr = ADW'(1); reg_wdata = 32'd1;
      step();
      frame_done = 1'b0; reg_wr = 1'b0; reg_wdata = '0;
      rd(1, v); chk("R8 set wins", v, 32'd1);

      // R6: partial clear
      wr(3, 32'h6);
      wr(1, 32'h2);
      rd(1, v); chk("R6 partial clear", v, 32'h5);
      step();
      chk("R9 irq bit2", {31'd0, irq}, 32'd1);
      wr(2, 32'h1FF);
      step();
      chk("R9 irq all masked", {31'd0, irq}, 32'd0);

      // R10: soft reset command
      wr(0, 32'h1);
      rd(16, v); chk("R10 other bit no effect cnt", v, 32'd15);
      rd(2, v); chk("R10 other bit no effect mask", v, 32'h1FF);
      wr(0, 32'h100);
      rd(16, v); chk("R10 counter0 cleared", v, 32'd0);
      rd(20, v); chk("R10 counter4 cleared", v, 32'd0);
      rd(1, v); chk("R10 status cleared", v, 32'd0);
      rd(2, v); chk("R10 mask cleared", v, 32'd0);
      step();
      chk("R10 irq low", {31'd0, irq}, 32'd0);

      done = 1'b1;
      summary();
      $finish;
   end
endmodule